// File: doc/BRIEF.md
# Status Channel Sync Monitor

This block follows the 2-bit status channel sent back by the receiver of a packet link. Each round starts with a framing word of 2'b11. After it come `cal_len_i * cal_rep_i` status slots, and the round ends with one DIP2 check word. The block walks the calendar with a slot index and a repeat index. Each slot's status word goes to the port named by a programmable slot-to-port map. Every port keeps its latest status, and the block turns that status into a credit grant for the transmit scheduler.

Two run-length counters watch the link. One counts consecutive rounds whose DIP2 word is wrong. The other counts consecutive framing words (2'b11) found where a status slot was expected. Each counter has its own 4-bit threshold, and a threshold of 0 turns that check off. When a count passes its threshold, the block declares loss of sync. From then on it withholds credit from every port that is not ignored, and the datapath sends training. This lasts until software pulses `resync_i`. A per-port ignore mask bypasses the channel altogether.

The status stream enters as a valid-qualified word stream. There is no ready signal: the monitor takes every word presented with `st_valid_i` high and never back-pressures its source. A word presented with valid low is dropped and does not advance the calendar. All other pins are plain level controls or one-cycle pulses.

Top module: `stat_sync_mon`

## Requirements
- R1: After reset every port that is not ignored shows credit code 2'b00 (none), and all error pulses and `sync_lost_o` are low.
- R2: A 2'b11 word on the stream starts a round. Each following slot word updates the status of the port that the map gives for that slot. Credit codes are 2'b00 none, 2'b01 small burst and 2'b10 full burst. Status 2'b00 (starving) maps to 2'b10, status 2'b01 (hungry) maps to 2'b01, and status 2'b10 (satisfied) maps to 2'b00.
- R3: A round holds `cal_len_i` slots repeated `cal_rep_i` times. Slot s uses map entry s, taken from bits [4s+3:4s] of `cal_map_i`. A repeat count of 0 acts as 1.
- R4: The word after the last slot is the DIP2 word. Its expected value is the bitwise inverse of the XOR of all slot words in the round. A mismatch gives a one-cycle `dip_err_o` pulse in the cycle after that word.
- R5: A 2'b11 word in a slot position gives a one-cycle `frm_err_o` pulse. It leaves that slot's port status unchanged and still counts in the DIP2 XOR.
- R6: Consecutive bad DIP2 rounds are counted, and a good DIP2 round clears the count. A bad round that finds the count already equal to or above a nonzero `dip_max_i` sets `sync_lost_o` and pulses `dip_lost_o` once. A threshold of 0 never causes loss.
- R7: Unexpected framing words are counted. The count clears when a DIP2 word ends a round that held none. A framing word that finds the count already equal to or above a nonzero `frm_max_i` sets `sync_lost_o` and pulses `frm_lost_o` once. A threshold of 0 never causes loss.
- R8: While `sync_lost_o` is high, every port that is not ignored shows credit 2'b00. `sync_lost_o` stays high until `resync_i`. A resync clears both counters, returns the framer to hunting for 2'b11 and sets every port's status to satisfied.
- R9: A port whose bit is set in `ign_i` always shows credit 2'b10, whatever its received status and the sync state.
- R10: With `cal_len_i` equal to 0 the calendar is inactive. Stream words are ignored and stored statuses stay untouched, while non-ignored ports show 2'b00.
- R11: A word presented with `st_valid_i` low has no effect on the calendar position, the DIP2 XOR or the counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| resync_i | input | 1 | Software resynchronization pulse |
| st_valid_i | input | 1 | Status word valid |
| st_word_i | input | 2 | Received status word |
| cal_len_i | input | 7 | Calendar length; 0 disables |
| cal_rep_i | input | 8 | Calendar repeat count |
| cal_map_i | input | CAL_SLOTS*4 | Port number for each slot |
| dip_max_i | input | 4 | DIP2 run threshold; 0 disables |
| frm_max_i | input | 4 | Framing run threshold; 0 disables |
| ign_i | input | NPORTS | Per-port status bypass |
| credit_o | output | NPORTS*2 | Per-port credit code |
| dip_err_o | output | 1 | Bad DIP2 pulse |
| frm_err_o | output | 1 | Unexpected framing pulse |
| dip_lost_o | output | 1 | Sync lost by DIP2 run pulse |
| frm_lost_o | output | 1 | Sync lost by framing run pulse |
| sync_lost_o | output | 1 | Loss of sync level |

## Verification
One set of rounds mixes all three status codes and places a later repeat over an earlier one. This separates a correct slot-to-port walk and repeat count from an off-by-one walk. Runs of bad DIP2 rounds, first broken by a good round and then not, tell a true consecutive count apart from a total count, and tell "exceeds" apart from "reaches". Framing words placed in slots, with a clean round between groups, show which words clear the framing run. Gaps with valid low, a zero repeat count, a zero length and ignored ports show that the bypass paths leave the stored state alone.

// File: rtl/ssm_pkg.sv
package ssm_pkg;
  typedef enum logic [1:0] {
    ST_STARVE = 2'b00,
    ST_HUNGRY = 2'b01,
    ST_SATIS  = 2'b10,
    ST_FRAME  = 2'b11
  } stat_code_e;

  typedef enum logic [1:0] {
    CR_NONE   = 2'b00,
    CR_BURST2 = 2'b01,
    CR_BURST1 = 2'b10
  } credit_e;

  typedef enum logic [1:0] {
    FR_HUNT = 2'b00,
    FR_SLOT = 2'b01,
    FR_DIP  = 2'b10
  } fr_state_e;

  function automatic credit_e credit_of(input logic [1:0] code);
    case (code)
      ST_STARVE: credit_of = CR_BURST1;
      ST_HUNGRY: credit_of = CR_BURST2;
      default:   credit_of = CR_NONE;
    endcase
  endfunction
endpackage

// File: rtl/ssm_framer.sv
module ssm_framer
  import ssm_pkg::*;
#(
  parameter int NPORTS    = 16,
  parameter int CAL_SLOTS = 16,
  parameter int LEN_W     = 7,
  parameter int REP_W     = 8,
  localparam int PORT_W   = $clog2(NPORTS),
  localparam int IDX_W    = $clog2(CAL_SLOTS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        resync_i,
  input  logic                        valid_i,
  input  logic [1:0]                  word_i,
  input  logic [LEN_W-1:0]            cal_len_i,
  input  logic [REP_W-1:0]            cal_rep_i,
  input  logic [CAL_SLOTS*PORT_W-1:0] cal_map_i,
  output logic                        active_o,
  output logic                        upd_o,
  output logic [PORT_W-1:0]           upd_port_o,
  output logic [1:0]                  upd_code_o,
  output logic                        frm_hit_o,
  output logic                        frm_clr_o,
  output logic                        dip_bad_o,
  output logic                        dip_good_o
);
  fr_state_e         state_q;
  logic [LEN_W-1:0]  slot_q;
  logic [REP_W-1:0]  rep_q;
  logic [1:0]        acc_q;
  logic              rnd_bad_q;

  logic              take;
  logic              slot_last;
  logic              rep_last;
  logic [REP_W-1:0]  rep_end;
  logic [1:0]        dip_exp;
  logic [IDX_W-1:0]  idx;

  assign active_o  = (cal_len_i != '0);
  assign take      = valid_i && active_o && !resync_i;
  assign rep_end   = (cal_rep_i == '0) ? '0 : REP_W'(cal_rep_i - 1'b1);
  assign slot_last = (slot_q >= LEN_W'(cal_len_i - 1'b1));
  assign rep_last  = (rep_q >= rep_end);
  assign dip_exp   = ~acc_q;
  assign idx       = slot_q[IDX_W-1:0];

  assign upd_port_o = cal_map_i[idx*PORT_W +: PORT_W];
  assign upd_code_o = word_i;
  assign upd_o      = take && (state_q == FR_SLOT) && (word_i != ST_FRAME);
  assign frm_hit_o  = take && (state_q == FR_SLOT) && (word_i == ST_FRAME);
  assign dip_bad_o  = take && (state_q == FR_DIP) && (word_i != dip_exp);
  assign dip_good_o = take && (state_q == FR_DIP) && (word_i == dip_exp);
  assign frm_clr_o  = take && (state_q == FR_DIP) && !rnd_bad_q;

  always_ff @(posedge clk) begin
    if (!rst_n || resync_i || !active_o) begin
      state_q   <= FR_HUNT;
      slot_q    <= '0;
      rep_q     <= '0;
      acc_q     <= '0;
      rnd_bad_q <= 1'b0;
    end else if (valid_i) begin
      case (state_q)
        FR_HUNT: begin
          if (word_i == ST_FRAME) begin
            state_q   <= FR_SLOT;
            slot_q    <= '0;
            rep_q     <= '0;
            acc_q     <= '0;
            rnd_bad_q <= 1'b0;
          end
        end
        FR_SLOT: begin
          acc_q <= acc_q ^ word_i;
          if (word_i == ST_FRAME) rnd_bad_q <= 1'b1;
          if (slot_last) begin
            slot_q <= '0;
            if (rep_last) begin
              state_q <= FR_DIP;
              rep_q   <= '0;
            end else begin
              rep_q <= rep_q + 1'b1;
            end
          end else begin
            slot_q <= slot_q + 1'b1;
          end
        end
        FR_DIP:  state_q <= FR_HUNT;
        default: state_q <= FR_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/ssm_run_cnt.sv
module ssm_run_cnt #(
  parameter int THR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             resync_i,
  input  logic             hit_i,
  input  logic             clr_i,
  input  logic [THR_W-1:0] thr_i,
  output logic             evt_o,
  output logic             trip_o,
  output logic             lost_o
);
  localparam logic [THR_W-1:0] CNT_MAX = '1;

  logic [THR_W-1:0] cnt_q;
  logic             trip_c;

  assign trip_c = hit_i && (thr_i != '0) && (cnt_q >= thr_i) && !lost_o;

  always_ff @(posedge clk) begin
    if (!rst_n || resync_i) begin
      cnt_q  <= '0;
      evt_o  <= 1'b0;
      trip_o <= 1'b0;
      lost_o <= 1'b0;
    end else begin
      evt_o  <= hit_i;
      trip_o <= trip_c;
      if (trip_c) lost_o <= 1'b1;
      if (hit_i) begin
        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      end else if (clr_i) begin
        cnt_q <= '0;
      end
    end
  end
endmodule

// File: rtl/ssm_credit.sv
module ssm_credit
  import ssm_pkg::*;
#(
  parameter int NPORTS  = 16,
  localparam int PORT_W = $clog2(NPORTS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                resync_i,
  input  logic                upd_i,
  input  logic [PORT_W-1:0]   upd_port_i,
  input  logic [1:0]          upd_code_i,
  input  logic                block_i,
  input  logic [NPORTS-1:0]   ign_i,
  output logic [NPORTS*2-1:0] credit_o
);
  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic [1:0] stat_q;

    always_ff @(posedge clk) begin
      if (!rst_n || resync_i) begin
        stat_q <= ST_SATIS;
      end else if (upd_i && (upd_port_i == PORT_W'(p))) begin
        stat_q <= upd_code_i;
      end
    end

    always_comb begin
      if (ign_i[p])     credit_o[2*p +: 2] = CR_BURST1;
      else if (block_i) credit_o[2*p +: 2] = CR_NONE;
      else              credit_o[2*p +: 2] = credit_of(stat_q);
    end
  end
endmodule

// File: rtl/stat_sync_mon.sv
module stat_sync_mon
  import ssm_pkg::*;
#(
  parameter int NPORTS    = 16,
  parameter int CAL_SLOTS = 16,
  parameter int LEN_W     = 7,
  parameter int REP_W     = 8,
  parameter int THR_W     = 4,
  localparam int PORT_W   = $clog2(NPORTS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        resync_i,
  input  logic                        st_valid_i,
  input  logic [1:0]                  st_word_i,
  input  logic [LEN_W-1:0]            cal_len_i,
  input  logic [REP_W-1:0]            cal_rep_i,
  input  logic [CAL_SLOTS*PORT_W-1:0] cal_map_i,
  input  logic [THR_W-1:0]            dip_max_i,
  input  logic [THR_W-1:0]            frm_max_i,
  input  logic [NPORTS-1:0]           ign_i,
  output logic [NPORTS*2-1:0]         credit_o,
  output logic                        dip_err_o,
  output logic                        frm_err_o,
  output logic                        dip_lost_o,
  output logic                        frm_lost_o,
  output logic                        sync_lost_o
);
  logic              active;
  logic              upd;
  logic [PORT_W-1:0] upd_port;
  logic [1:0]        upd_code;
  logic              frm_hit, frm_clr, dip_bad, dip_good;
  logic              dip_lost_lvl, frm_lost_lvl;

  ssm_framer #(
    .NPORTS(NPORTS), .CAL_SLOTS(CAL_SLOTS), .LEN_W(LEN_W), .REP_W(REP_W)
  ) u_framer (
    .clk(clk), .rst_n(rst_n), .resync_i(resync_i),
    .valid_i(st_valid_i), .word_i(st_word_i),
    .cal_len_i(cal_len_i), .cal_rep_i(cal_rep_i), .cal_map_i(cal_map_i),
    .active_o(active), .upd_o(upd), .upd_port_o(upd_port), .upd_code_o(upd_code),
    .frm_hit_o(frm_hit), .frm_clr_o(frm_clr),
    .dip_bad_o(dip_bad), .dip_good_o(dip_good)
  );

  ssm_run_cnt #(.THR_W(THR_W)) u_dip_run (
    .clk(clk), .rst_n(rst_n), .resync_i(resync_i),
    .hit_i(dip_bad), .clr_i(dip_good), .thr_i(dip_max_i),
    .evt_o(dip_err_o), .trip_o(dip_lost_o), .lost_o(dip_lost_lvl)
  );

  ssm_run_cnt #(.THR_W(THR_W)) u_frm_run (
    .clk(clk), .rst_n(rst_n), .resync_i(resync_i),
    .hit_i(frm_hit), .clr_i(frm_clr), .thr_i(frm_max_i),
    .evt_o(frm_err_o), .trip_o(frm_lost_o), .lost_o(frm_lost_lvl)
  );

  assign sync_lost_o = dip_lost_lvl | frm_lost_lvl;

  ssm_credit #(.NPORTS(NPORTS)) u_credit (
    .clk(clk), .rst_n(rst_n), .resync_i(resync_i),
    .upd_i(upd), .upd_port_i(upd_port), .upd_code_i(upd_code),
    .block_i(sync_lost_o | !active), .ign_i(ign_i), .credit_o(credit_o)
  );
endmodule

// File: rtl/ssm_sva.sv
module ssm_sva #(
  parameter int NPORTS = 16,
  parameter int LEN_W  = 7
) (
  input logic                clk,
  input logic                rst_n,
  input logic                resync_i,
  input logic [LEN_W-1:0]    cal_len_i,
  input logic [NPORTS-1:0]   ign_i,
  input logic [NPORTS*2-1:0] credit_o,
  input logic                dip_err_o,
  input logic                frm_err_o,
  input logic                dip_lost_o,
  input logic                frm_lost_o,
  input logic                sync_lost_o
);
  a_r4_dip_pulse_short: assert property (@(posedge clk) disable iff (!rst_n)
    dip_err_o |=> !dip_err_o);

  a_r6_dip_trip_lost: assert property (@(posedge clk) disable iff (!rst_n)
    dip_lost_o |-> sync_lost_o);

  a_r7_frm_trip_lost: assert property (@(posedge clk) disable iff (!rst_n)
    frm_lost_o |-> sync_lost_o);

  a_r7_frm_trip_has_evt: assert property (@(posedge clk) disable iff (!rst_n)
    frm_lost_o |-> frm_err_o);

  a_r8_lost_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_lost_o && !resync_i) |=> sync_lost_o);

  a_r8_resync_clears: assert property (@(posedge clk) disable iff (!rst_n)
    resync_i |=> !sync_lost_o);

  for (genvar p = 0; p < NPORTS; p++) begin : g_chk
    a_r9_ign_full: assert property (@(posedge clk) disable iff (!rst_n)
      ign_i[p] |-> (credit_o[2*p +: 2] == 2'b10));

    a_r8_lost_no_credit: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_lost_o && !ign_i[p]) |-> (credit_o[2*p +: 2] == 2'b00));

    a_r10_idle_no_credit: assert property (@(posedge clk) disable iff (!rst_n)
      ((cal_len_i == '0) && !ign_i[p]) |-> (credit_o[2*p +: 2] == 2'b00));

    a_r2_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
      credit_o[2*p +: 2] != 2'b11);
  end
endmodule

bind stat_sync_mon ssm_sva #(.NPORTS(NPORTS), .LEN_W(LEN_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .resync_i(resync_i), .cal_len_i(cal_len_i),
  .ign_i(ign_i), .credit_o(credit_o), .dip_err_o(dip_err_o),
  .frm_err_o(frm_err_o), .dip_lost_o(dip_lost_o), .frm_lost_o(frm_lost_o),
  .sync_lost_o(sync_lost_o)
);

// File: tb/stat_sync_mon_tb.sv
module stat_sync_mon_tb;
  localparam int NP = 16;
  localparam int NS = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            resync_i = 1'b0;
  logic            st_valid_i = 1'b0;
  logic [1:0]      st_word_i = 2'b00;
  logic [6:0]      cal_len_i = 7'd4;
  logic [7:0]      cal_rep_i = 8'd2;
  logic [NS*4-1:0] cal_map_i;
  logic [3:0]      dip_max_i = 4'd0;
  logic [3:0]      frm_max_i = 4'd0;
  logic [NP-1:0]   ign_i = '0;
  logic [NP*2-1:0] credit_o;
  logic dip_err_o, frm_err_o, dip_lost_o, frm_lost_o, sync_lost_o;

  int n_chk = 0, n_bad = 0;
  int n_dip = 0, n_frm = 0, n_diplost = 0, n_frmlost = 0;
  logic [1:0] acc;
  bit done = 0;

  always #4 clk = ~clk;

  stat_sync_mon u_dut (
    .clk(clk), .rst_n(rst_n), .resync_i(resync_i),
    .st_valid_i(st_valid_i), .st_word_i(st_word_i),
    .cal_len_i(cal_len_i), .cal_rep_i(cal_rep_i), .cal_map_i(cal_map_i),
    .dip_max_i(dip_max_i), .frm_max_i(frm_max_i), .ign_i(ign_i),
    .credit_o(credit_o), .dip_err_o(dip_err_o), .frm_err_o(frm_err_o),
    .dip_lost_o(dip_lost_o), .frm_lost_o(frm_lost_o), .sync_lost_o(sync_lost_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int cr(input int p);
    return int'(credit_o[2*p +: 2]);
  endfunction

  task automatic sample();
    if (dip_err_o)  n_dip++;
    if (frm_err_o)  n_frm++;
    if (dip_lost_o) n_diplost++;
    if (frm_lost_o) n_frmlost++;
  endtask

  task automatic clear_seen();
    n_dip = 0; n_frm = 0; n_diplost = 0; n_frmlost = 0;
  endtask

  task automatic send(input logic [1:0] w);
    st_word_i = w; st_valid_i = 1'b1;
    @(negedge clk);
    st_valid_i = 1'b0;
    sample();
  endtask

  task automatic idle(input logic [1:0] w);
    st_word_i = w; st_valid_i = 1'b0;
    @(negedge clk);
    sample();
  endtask

  task automatic frame();
    send(2'b11); acc = 2'b00;
  endtask

  task automatic slot(input logic [1:0] w);
    send(w); acc = acc ^ w;
  endtask

  task automatic dip(input bit bad);
    send(bad ? acc : ~acc);
  endtask

  task automatic round(input logic [15:0] v, input bit bad);
    frame();
    for (int i = 0; i < 8; i++) slot(v[2*i +: 2]);
    dip(bad);
  endtask

  task automatic do_resync();
    resync_i = 1'b1;
    @(negedge clk);
    resync_i = 1'b0;
    sample();
  endtask

  // R1
  task automatic t_reset();
    for (int p = 0; p < NP; p++) chk("R1 credit after reset", cr(p), 0);
    chk("R1 sync_lost after reset", int'(sync_lost_o), 0);
    chk("R1 pulses after reset", int'(dip_err_o | frm_err_o | dip_lost_o | frm_lost_o), 0);
  endtask

  // R2 R3 R4
  task automatic t_round();
    clear_seen();
    frame();
    slot(2'b00); slot(2'b01); slot(2'b10); slot(2'b00);
    chk("R3 port0 after first repeat", cr(0), 2);
    chk("R3 port2 satisfied after first repeat", cr(2), 0);
    slot(2'b01); slot(2'b00); slot(2'b00); slot(2'b01);
    dip(0);
    chk("R2 port0 hungry", cr(0), 1);
    chk("R2 port1 starving", cr(1), 2);
    chk("R3 port2 overwritten", cr(2), 2);
    chk("R2 port3 hungry", cr(3), 1);
    chk("R2 unmapped port4", cr(4), 0);
    chk("R4 good dip no pulse", n_dip, 0);
  endtask

  // R3 repeat count zero
  task automatic t_rep0();
    cal_rep_i = 8'd0;
    clear_seen();
    frame();
    slot(2'b01); slot(2'b00); slot(2'b01); slot(2'b00);
    dip(0);
    chk("R3 rep0 dip", n_dip, 0);
    chk("R3 rep0 no framing", n_frm, 0);
    chk("R3 rep0 port0", cr(0), 1);
    chk("R3 rep0 port1", cr(1), 2);
    cal_rep_i = 8'd2;
  endtask

  // R11
  task automatic t_valid();
    clear_seen();
    frame();
    slot(2'b01); slot(2'b01);
    idle(2'b11); idle(2'b10); idle(2'b11);
    slot(2'b01); slot(2'b01); slot(2'b01); slot(2'b01); slot(2'b01); slot(2'b01);
    dip(0);
    chk("R11 gap no framing error", n_frm, 0);
    chk("R11 gap no dip error", n_dip, 0);
    chk("R11 port2 hungry", cr(2), 1);
  endtask

  // R4 R6 R8
  task automatic t_dip();
    dip_max_i = 4'd2;
    clear_seen();
    round(16'h5555, 1);
    chk("R4 bad dip pulse", n_dip, 1);
    round(16'h5555, 0);
    round(16'h5555, 1);
    round(16'h5555, 1);
    chk("R6 run broken by good round", int'(sync_lost_o), 0);
    chk("R6 no trip at threshold", n_diplost, 0);
    round(16'h5555, 1);
    chk("R6 trip past threshold", n_diplost, 1);
    chk("R6 sync lost", int'(sync_lost_o), 1);
    chk("R8 credit withheld", cr(0), 0);
    round(16'h5555, 1);
    chk("R6 single trip pulse", n_diplost, 1);
    do_resync();
    chk("R8 resync clears lost", int'(sync_lost_o), 0);
    round(16'h0000, 0);
    chk("R8 credit back after resync", cr(1), 2);
  endtask

  // R6 threshold zero
  task automatic t_dip_off();
    dip_max_i = 4'd0;
    clear_seen();
    for (int k = 0; k < 4; k++) round(16'h5555, 1);
    chk("R6 disabled pulses", n_dip, 4);
    chk("R6 disabled no loss", int'(sync_lost_o), 0);
  endtask

  // R5 R7
  task automatic t_frm();
    do_resync();
    frm_max_i = 4'd2;
    round(16'h5555, 0);
    clear_seen();
    round(16'h0C0C, 0);
    chk("R5 framing pulses", n_frm, 2);
    chk("R5 port1 unchanged", cr(1), 1);
    chk("R5 port0 updated", cr(0), 2);
    chk("R5 dip still good", n_dip, 0);
    round(16'h0000, 0);
    round(16'h0C0C, 0);
    chk("R7 clean round clears run", n_frmlost, 0);
    round(16'h000C, 0);
    chk("R7 trip past threshold", n_frmlost, 1);
    chk("R7 sync lost", int'(sync_lost_o), 1);
  endtask

  // R9
  task automatic t_ign();
    ign_i = 16'h0021;
    #1;
    chk("R9 port0 ignored while lost", cr(0), 2);
    chk("R9 port5 ignored", cr(5), 2);
    chk("R8 port1 withheld", cr(1), 0);
    do_resync();
    round(16'h8282, 0);
    chk("R9 port0 ignores satisfied", cr(0), 2);
    chk("R2 port3 satisfied", cr(3), 0);
    ign_i = '0;
  endtask

  // R10
  task automatic t_len0();
    round(16'h0000, 0);
    cal_len_i = 7'd0;
    #1;
    chk("R10 inactive no credit", cr(0), 0);
    clear_seen();
    send(2'b11);
    for (int i = 0; i < 8; i++) send(2'b10);
    send(2'b11); send(2'b11);
    chk("R10 inactive no framing", n_frm, 0);
    cal_len_i = 7'd4;
    #1;
    chk("R10 statuses untouched", cr(2), 2);
  endtask

  initial begin
    for (int s = 0; s < NS; s++) cal_map_i[4*s +: 4] = 4'(s);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_round();
    t_rep0();
    t_valid();
    t_dip();
    t_dip_off();
    t_frm();
    t_ign();
    t_len0();
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule